// File: doc/BRIEF.md
# Sixteen-Tap All-Pole Synthesis Filter

This block rebuilds a speech waveform from an excitation signal. Each incoming 16-bit excitation sample is scaled by a programmable 32-bit gain. The block adds a weighted sum of the sixteen most recent filter results, which it keeps in an internal history. It then emits one rounded, saturated 16-bit output sample and pushes a rescaled copy of the unrounded result into the history.

The arithmetic uses fixed point throughout. Coefficients are signed Q12 values, so they span -8.0 up to just below +8.0. History entries are signed 32-bit Q14, the gain is signed 32-bit Q26, and the running sum is Q10. Every product is a 32x16 multiply that keeps the upper part of the 48-bit result. The prediction sum wraps. Saturation is applied only where the excitation joins the prediction, at the output and on the history write.

One multiply-accumulate step is done per clock, so a sample takes seventeen cycles from acceptance to output. Software loads coefficients and gain between samples and can clear the history at any idle point.

Top module: `ar_synth_filter`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_sample is 0, the gain and all coefficients are 0, and the history is all zero.
- R2: A sample is accepted on a clock edge where in_valid and in_ready are both 1. out_valid rises exactly 17 clock edges after that acceptance edge. in_ready stays 0 from the acceptance edge until that output edge.
- R3: Coefficient k (index written on coef_idx, 0 to 15) weights the history entry written k+1 samples earlier, so coefficient 0 weights the newest entry. Each tap term is (history × coefficient) arithmetically shifted right by 16.
- R4: The sixteen tap terms are summed modulo 2^32 (two's-complement wraparound), with no saturation inside this sum.
- R5: The excitation term is (gain × sample) arithmetically shifted right by 16. It is added to the prediction with saturation to the signed 32-bit range.
- R6: out_sample equals the saturated sum plus 512, arithmetically shifted right by 10, then clamped to [-32768, 32767].
- R7: For each sample, the history ages by one position and the oldest entry is dropped. The new newest entry is the saturated sum shifted left by 4, clamped to the signed 32-bit range.
- R8: Writes on coef_we or gain_we are taken only when no sample is in flight, including on the acceptance edge itself. While a sample is in flight they have no effect.
- R9: clr_hist zeroes every history entry on an edge where no sample is in flight; while a sample is in flight it has no effect. in_ready is 0 in any cycle where clr_hist is 1.
- R10: out_valid is a single-cycle pulse, and out_sample changes only on the edge that raises out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_hist | input | 1 | Clear the history (idle only) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Coefficient index, 0 = newest tap |
| coef_data | input | 16 | Signed Q12 coefficient |
| gain_we | input | 1 | Gain write strobe |
| gain_data | input | 32 | Signed Q26 gain |
| in_valid | input | 1 | Excitation sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 16 | Signed excitation sample |
| out_valid | output | 1 | One-cycle output strobe |
| out_sample | output | 16 | Signed synthesized sample |

## Verification
A single-tap impulse pattern shows which past result each coefficient index weights, and confirms the seventeen-cycle latency. Half-step inputs at a gain of one half separate round-half-up from truncation or rounding toward zero. Full-scale inputs at maximum gain fill the history with clamped values, after which all-maximum coefficients separate a wrapping prediction sum from a saturating one. Two heavy taps plus full-scale excitation then show that the excitation add saturates instead of wrapping. Writes and clears issued in mid-flight, followed by long random streams with occasional clears, are compared every clock against a behavioural model.

// File: rtl/ar_synth_pkg.sv
package ar_synth_pkg;

  localparam int SMP_W      = 16;
  localparam int COEF_W     = 16;
  localparam int HIST_W     = 32;
  localparam int GAIN_W     = 32;
  localparam int PROD_SHIFT = 16;
  localparam int OUT_SHIFT  = 10;
  localparam int HIST_LSH   = 4;
  localparam int PROD_W     = HIST_W + COEF_W;
  localparam int RND_W      = HIST_W + 2;
  localparam int Q_W        = RND_W - OUT_SHIFT;

  localparam logic signed [HIST_W-1:0] S32_MAX = {1'b0, {(HIST_W-1){1'b1}}};
  localparam logic signed [HIST_W-1:0] S32_MIN = {1'b1, {(HIST_W-1){1'b0}}};
  localparam logic signed [SMP_W-1:0]  S16_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic signed [SMP_W-1:0]  S16_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MAC  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;

  // wide value times narrow value, keep the upper word of the product
  function automatic logic signed [HIST_W-1:0] upper_mul(
    input logic signed [HIST_W-1:0] wide,
    input logic signed [COEF_W-1:0] narrow
  );
    logic signed [PROD_W-1:0] prod;
    prod = PROD_W'(wide) * PROD_W'(narrow);
    return HIST_W'(prod >>> PROD_SHIFT);
  endfunction

  function automatic logic signed [HIST_W-1:0] add_clamp32(
    input logic signed [HIST_W-1:0] a,
    input logic signed [HIST_W-1:0] b
  );
    logic signed [HIST_W:0] s;
    s = {a[HIST_W-1], a} + {b[HIST_W-1], b};
    if (s[HIST_W] != s[HIST_W-1])
      return s[HIST_W] ? S32_MIN : S32_MAX;
    return s[HIST_W-1:0];
  endfunction

  function automatic logic signed [SMP_W-1:0] round_to_sample(
    input logic signed [HIST_W-1:0] q10
  );
    logic signed [RND_W-1:0] t;
    logic signed [Q_W-1:0]   q;
    t = RND_W'(q10) + RND_W'(1 <<< (OUT_SHIFT - 1));
    q = Q_W'(t >>> OUT_SHIFT);
    if (q > Q_W'(S16_MAX)) return S16_MAX;
    if (q < Q_W'(S16_MIN)) return S16_MIN;
    return q[SMP_W-1:0];
  endfunction

  function automatic logic signed [HIST_W-1:0] lift_to_history(
    input logic signed [HIST_W-1:0] q10
  );
    logic [HIST_LSH:0] top;
    top = q10[HIST_W-1 -: HIST_LSH+1];
    if ((top == '0) || (top == '1))
      return {q10[HIST_W-1-HIST_LSH:0], {HIST_LSH{1'b0}}};
    return q10[HIST_W-1] ? S32_MIN : S32_MAX;
  endfunction

endpackage

// File: rtl/ar_coef_bank.sv
module ar_coef_bank
  import ar_synth_pkg::*;
#(
  parameter int ORDER = 16,
  localparam int IW   = $clog2(ORDER)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          locked,
  input  logic                          coef_we,
  input  logic [IW-1:0]                 coef_idx,
  input  logic signed [COEF_W-1:0]      coef_data,
  input  logic                          gain_we,
  input  logic signed [GAIN_W-1:0]      gain_data,
  input  logic [IW-1:0]                 tap_sel,
  output logic signed [COEF_W-1:0]      coef_tap,
  output logic signed [GAIN_W-1:0]      gain_q,
  output logic [ORDER*COEF_W-1:0]       coef_flat
);

  logic signed [COEF_W-1:0] coef_q [ORDER];
  logic                     coef_take;
  logic                     gain_take;

  assign coef_take = coef_we && !locked;
  assign gain_take = gain_we && !locked;

  for (genvar k = 0; k < ORDER; k++) begin : g_coef
    logic hit;
    assign hit = coef_take && (coef_idx == IW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   coef_q[k] <= '0;
      else if (hit) coef_q[k] <= coef_data;
    end
    assign coef_flat[k*COEF_W +: COEF_W] = coef_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gain_q <= '0;
    else if (gain_take) gain_q <= gain_data;
  end

  assign coef_tap = coef_q[tap_sel];

endmodule

// File: rtl/ar_history.sv
module ar_history
  import ar_synth_pkg::*;
#(
  parameter int ORDER = 16,
  localparam int IW   = $clog2(ORDER)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_take,
  input  logic                     push_en,
  input  logic signed [HIST_W-1:0] push_val,
  input  logic [IW-1:0]            rd_sel,
  output logic signed [HIST_W-1:0] rd_val,
  output logic                     all_zero
);

  logic signed [HIST_W-1:0] stage_q [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic signed [HIST_W-1:0] feed;
    if (k == 0) begin : g_head
      assign feed = push_val;
    end else begin : g_body
      assign feed = stage_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[k] <= '0;
      else if (clr_take) stage_q[k] <= '0;
      else if (push_en)  stage_q[k] <= feed;
    end
  end

  always_comb begin
    all_zero = 1'b1;
    for (int k = 0; k < ORDER; k++)
      if (stage_q[k] != '0) all_zero = 1'b0;
  end

  assign rd_val = stage_q[rd_sel];

endmodule

// File: rtl/ar_mac_seq.sv
module ar_mac_seq
  import ar_synth_pkg::*;
#(
  parameter int ORDER = 16,
  localparam int IW   = $clog2(ORDER)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_hist,
  input  logic                     in_valid,
  input  logic signed [SMP_W-1:0]  in_sample,
  output logic                     in_ready,
  input  logic signed [HIST_W-1:0] hist_tap,
  input  logic signed [COEF_W-1:0] coef_tap,
  input  logic signed [GAIN_W-1:0] gain_q,
  output logic [IW-1:0]            tap_sel,
  output logic                     busy,
  output logic                     mac_last,
  output logic                     fin_stage,
  output logic                     push_en,
  output logic signed [HIST_W-1:0] push_val,
  output logic                     out_valid,
  output logic signed [SMP_W-1:0]  out_sample
);

  localparam logic [IW-1:0] LAST_TAP = IW'(ORDER - 1);

  phase_t                   phase_q;
  logic [IW-1:0]            tap_q;
  logic signed [HIST_W-1:0] acc_q;
  logic signed [SMP_W-1:0]  smp_q;
  logic signed [HIST_W-1:0] term;
  logic signed [HIST_W-1:0] excite;
  logic signed [HIST_W-1:0] total;
  logic                     accept;

  assign busy      = (phase_q != PH_IDLE);
  assign in_ready  = !busy && !clr_hist;
  assign accept    = in_valid && in_ready;
  assign mac_last  = (phase_q == PH_MAC) && (tap_q == LAST_TAP);
  assign fin_stage = (phase_q == PH_FIN);
  assign tap_sel   = tap_q;

  assign term     = upper_mul(hist_tap, coef_tap);
  assign excite   = upper_mul(gain_q, smp_q);
  assign total    = add_clamp32(acc_q, excite);
  assign push_en  = fin_stage;
  assign push_val = lift_to_history(total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      tap_q      <= '0;
      acc_q      <= '0;
      smp_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_MAC;
            tap_q   <= '0;
            acc_q   <= '0;
            smp_q   <= in_sample;
          end
        end
        PH_MAC: begin
          acc_q <= acc_q + term;
          tap_q <= tap_q + 1'b1;
          if (tap_q == LAST_TAP) phase_q <= PH_FIN;
        end
        PH_FIN: begin
          out_sample <= round_to_sample(total);
          out_valid  <= 1'b1;
          phase_q    <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ar_synth_filter.sv
module ar_synth_filter
  import ar_synth_pkg::*;
#(
  parameter int ORDER = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_hist,
  input  logic                       coef_we,
  input  logic [$clog2(ORDER)-1:0]   coef_idx,
  input  logic [15:0]                coef_data,
  input  logic                       gain_we,
  input  logic [31:0]                gain_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [15:0]                in_sample,
  output logic                       out_valid,
  output logic [15:0]                out_sample
);

  localparam int IW = $clog2(ORDER);

  logic                     busy;
  logic                     mac_last;
  logic                     fin_stage;
  logic                     clr_take;
  logic                     hist_zero;
  logic                     push_en;
  logic signed [HIST_W-1:0] push_val;
  logic [IW-1:0]            tap_sel;
  logic signed [HIST_W-1:0] hist_tap;
  logic signed [COEF_W-1:0] coef_tap;
  logic signed [GAIN_W-1:0] gain_q;
  logic [ORDER*COEF_W-1:0]  coef_flat;
  logic signed [SMP_W-1:0]  out_s;

  assign clr_take   = clr_hist && !busy;
  assign out_sample = out_s;

  ar_coef_bank #(.ORDER(ORDER)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (busy),
    .coef_we   (coef_we),
    .coef_idx  (coef_idx),
    .coef_data ($signed(coef_data)),
    .gain_we   (gain_we),
    .gain_data ($signed(gain_data)),
    .tap_sel   (tap_sel),
    .coef_tap  (coef_tap),
    .gain_q    (gain_q),
    .coef_flat (coef_flat)
  );

  ar_history #(.ORDER(ORDER)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_take (clr_take),
    .push_en  (push_en),
    .push_val (push_val),
    .rd_sel   (tap_sel),
    .rd_val   (hist_tap),
    .all_zero (hist_zero)
  );

  ar_mac_seq #(.ORDER(ORDER)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_hist   (clr_hist),
    .in_valid   (in_valid),
    .in_sample  ($signed(in_sample)),
    .in_ready   (in_ready),
    .hist_tap   (hist_tap),
    .coef_tap   (coef_tap),
    .gain_q     (gain_q),
    .tap_sel    (tap_sel),
    .busy       (busy),
    .mac_last   (mac_last),
    .fin_stage  (fin_stage),
    .push_en    (push_en),
    .push_val   (push_val),
    .out_valid  (out_valid),
    .out_sample (out_s)
  );

endmodule

// File: rtl/ar_synth_checker.sv
module ar_synth_checker #(
  parameter int CW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic [15:0]   out_sample,
  input logic          busy,
  input logic          mac_last,
  input logic          fin_stage,
  input logic          clr_take,
  input logic          hist_zero,
  input logic [CW-1:0] coef_flat,
  input logic [31:0]   gain_q
);

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R2
  AST_LAST_TAP_TO_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    mac_last |=> fin_stage); // R2
  AST_FIN_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_stage |=> out_valid); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R10
  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample)); // R10
  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(coef_flat)); // R8
  AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(gain_q)); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_take |=> hist_zero); // R9

endmodule

bind ar_synth_filter ar_synth_checker #(.CW(ORDER*16)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .busy       (busy),
  .mac_last   (mac_last),
  .fin_stage  (fin_stage),
  .clr_take   (clr_take),
  .hist_zero  (hist_zero),
  .coef_flat  (coef_flat),
  .gain_q     (gain_q)
);

// File: tb/ar_synth_filter_tb.sv
module ar_synth_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_hist = 1'b0;
  logic        coef_we = 1'b0;
  logic [3:0]  coef_idx = '0;
  logic [15:0] coef_data = '0;
  logic        gain_we = 1'b0;
  logic [31:0] gain_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_sample;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ar_synth_filter dut_i (
    .clk(clk), .rst_n(rst_n), .clr_hist(clr_hist),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .gain_we(gain_we), .gain_data(gain_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference, advanced once per clock ----------
  int m_hist[$];
  int m_coef[16];
  int m_gain = 0;
  int m_smp = 0;
  bit m_busy = 0;
  int m_left = 0;
  bit m_valid = 0;
  int m_out = 0;

  function automatic longint clamp(longint v, longint lo, longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic model_sample();
    int pred = 0;
    longint full, rnd, lift;
    for (int k = 0; k < 16; k++)
      pred += int'((longint'(m_hist[k]) * longint'(m_coef[k])) >>> 16);
    full = clamp(longint'(pred) + ((longint'(m_gain) * longint'(m_smp)) >>> 16),
                 -64'sd2147483648, 64'sd2147483647);
    rnd  = (full + 512) >>> 10;
    m_out = int'(clamp(rnd, -32768, 32767));
    lift = clamp(full * 16, -64'sd2147483648, 64'sd2147483647);
    m_hist.push_front(int'(lift));
    void'(m_hist.pop_back());
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      m_hist.push_back(0);
      m_coef[k] = 0;
    end
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      #2;
      chk("R2/R9 in_ready", in_ready, (!m_busy && !clr_hist));
      chk("R10 out_valid", out_valid, m_valid);
      chk("R6 out_sample", $signed(out_sample), m_out);
      m_valid = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          model_sample();
          m_valid = 1;
          m_busy = 0;
        end
      end else begin
        if (coef_we) m_coef[coef_idx] = int'($signed(coef_data));
        if (gain_we) m_gain = int'($signed(gain_data));
        if (clr_hist) begin
          for (int k = 0; k < 16; k++) m_hist[k] = 0;
        end else if (in_valid) begin
          m_busy = 1;
          m_left = 17;
          m_smp = int'($signed(in_sample));
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wcoef(int idx, int val);
    @(negedge clk);
    coef_we = 1; coef_idx = 4'(idx); coef_data = 16'(val);
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic wgain(longint val);
    @(negedge clk);
    gain_we = 1; gain_data = 32'(val);
    @(negedge clk);
    gain_we = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clr_hist = 1;
    @(negedge clk);
    clr_hist = 0;
  endtask

  task automatic start(int x);
    @(negedge clk);
    in_valid = 1; in_sample = 16'(x);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic finish(output int y, output int lat);
    lat = 0;
    forever begin
      @(negedge clk);
      #2;
      lat++;
      if (out_valid) break;
    end
    y = int'($signed(out_sample));
  endtask

  task automatic send(int x, output int y);
    int lat;
    start(x);
    finish(y, lat);
  endtask

  task automatic zero_coefs();
    for (int k = 0; k < 16; k++) wcoef(k, 0);
  endtask

  // ---------------- scenario ----------------
  initial begin
    int y, lat;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_sample", $signed(out_sample), 0);
    @(negedge clk);
    rst_n = 1;

    // R1: history and coefficients zero, so output is pure excitation
    wgain(64'sd67108864);
    send(77, y);
    chk("R1 empty history", y, 77);
    pulse_clear();

    // R3 ordering with a single unit tap at index 3, and R2 latency
    wcoef(3, 4096);
    start(1000);
    finish(y, lat);
    chk("R2 latency", lat, 17);
    chk("R3 impulse", y, 1000);
    for (int n = 1; n <= 8; n++) begin
      send(0, y);
      chk("R3 echo", y, ((n % 4) == 0) ? 1000 : 0);
    end

    // R9 clear at idle wipes the echoes
    pulse_clear();
    for (int n = 0; n < 4; n++) send(0, y);
    chk("R9 cleared echo", y, 0);

    // R6 rounding and output clamp
    wcoef(3, 0);
    wgain(64'sd33554432);
    send(3, y);  chk("R6 round +1.5", y, 2);
    send(-3, y); chk("R6 round -1.5", y, -1);
    send(1, y);  chk("R6 round +0.5", y, 1);
    send(-1, y); chk("R6 round -0.5", y, 0);
    wgain(64'sd268435456);
    send(30000, y);  chk("R6 clamp high", y, 32767);
    send(-30000, y); chk("R6 clamp low", y, -32768);

    // R8 writes during a sample are dropped
    pulse_clear();
    wgain(64'sd67108864);
    start(100);
    wgain(0);
    wcoef(0, 4096);
    finish(y, lat);
    chk("R8 gain kept", y, 100);
    send(0, y);  chk("R8 coef kept", y, 0);
    send(50, y); chk("R8 gain still kept", y, 50);

    // R9 clear during a sample is dropped; clear blocks acceptance
    wcoef(0, 4096);
    pulse_clear();
    start(100);
    pulse_clear();
    finish(y, lat);
    chk("R9 busy clear out", y, 100);
    send(0, y);
    chk("R9 busy clear ignored", y, 100);
    @(negedge clk);
    clr_hist = 1; in_valid = 1; in_sample = 16'(500);
    #2;
    chk("R9 ready low on clear", in_ready, 0);
    @(negedge clk);
    clr_hist = 0; in_valid = 0;
    send(0, y);
    chk("R9 clear beat input", y, 0);

    // saturated history, wrapping prediction, clamped excitation add
    pulse_clear();
    zero_coefs();
    wgain(64'sd2147483647);
    for (int n = 0; n < 16; n++) send(32767, y);
    chk("R6 full scale", y, 32767);
    for (int k = 0; k < 16; k++) wcoef(k, 32767);
    send(0, y);
    chk("R4 wrapped sum", y, -512);
    zero_coefs();
    wcoef(1, 16);
    send(0, y);
    chk("R7 clamped history", y, 512);
    wcoef(1, 0);
    wcoef(2, 32767);
    wcoef(3, 32767);
    send(32767, y);
    chk("R5 clamped add", y, 32767);

    // random streams, model compares every clock
    pulse_clear();
    for (int n = 0; n < 200; n++) begin
      if ((n % 25) == 0) begin
        for (int k = 0; k < 16; k++) wcoef(k, $signed($urandom_range(0, 4095)) - 2048);
        wgain(longint'($urandom_range(0, 134217727)));
      end
      if ((n % 60) == 59) pulse_clear();
      send(int'($urandom_range(0, 65535)) - 32768, y);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule